// File: doc/BRIEF.md
# Calendar Timekeeper with Committed Time Load

This block keeps wall-clock time and date as seven counters: second, minute, hour, day of month, day of week, month and year. A one-second strobe from outside advances the calendar. The calendar handles 30- and 31-day months and a February that has 28 or 29 days. The year counter holds 7 bits. It counts years from 1968, so it covers 1968 through 2095 and then wraps.

Software sets the time over a simple single-cycle register bus. Field writes never reach the running counters directly. They land in a staging copy. A write of 1 to a separate load register starts a short busy period. When that period ends, the whole staging copy moves into the counters in one clock, so software never sees a torn time. While the load is pending, a busy flag in the status register reads 1. Reads of the time fields always return the running counters.

Top module: `calendar_timekeeper`

## Requirements
- R1: After reset the counters read second 0, minute 0, hour 0, day of month 1, day of week 0, month 1, year 0. The status register reads 0.
- R2: Register map (byte addresses, 16-bit slots): status at 0x00 with busy on bit 6, load trigger at 0x3C, second 0x0A, minute 0x0C, hour 0x0E, day of month 0x10, day of week 0x12, month 0x14, year 0x16. A field reads as its running value, zero-extended. The trigger and any unmapped address read 0.
- R3: A write to 0x3C with wdata bit 0 set, made while busy is 0, raises busy for BUSY_CYCLES clocks, counted from the write edge. At the next edge all seven staged fields are copied into the counters together and busy returns to 0. A trigger written while busy is 1 is ignored.
- R4: A field write changes only the staged copy. The running value read back is unchanged until a load completes.
- R5: A staged field keeps only its low bits: 6 for second and minute, 5 for hour and day of month, 3 for day of week, 4 for month, 7 for year.
- R6: Each clock with tick_i high advances the second. A second of 59 or more wraps to 0 and carries into the minute. A minute of 59 or more wraps and carries into the hour. An hour of 23 or more wraps to 0 and ends the day. At each day end the day of week steps 0..6 and then wraps to 0.
- R7: At day end, a day of month that has reached the month length returns to 1. Otherwise it increments. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year field is a multiple of 4 and 28 days otherwise. All other months have 31 days.
- R8: When the day of month wraps, month 12 (or more) goes to 1 and the year increments. Year 127 wraps to 0.
- R9: A tick in the same clock as the load copy is dropped, and the loaded values stand.
- R10: With no tick and no load, the running values do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance strobe, one clock wide |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |

## Verification
The tick and the end of a load can fall in the same clock. When they do, the load must win and the tick must vanish. The bench forces this case directly: it counts BUSY_CYCLES clocks after a trigger and raises tick_i on exactly the copy edge. It then expects the loaded second, not the loaded second plus one, and expects the next tick to add exactly one. Randomly mixed ticks, triggers and field writes also hit the overlap by chance. A reference model that applies the same precedence judges every read-back.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int NUM_FIELDS = 7;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] month;
    logic [2:0] wday;
    logic [4:0] mday;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [5:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 7'd0, month: 4'd1, wday: 3'd0, mday: 5'd1,
                                 hour: 5'd0, minute: 6'd0, sec: 6'd0};

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                      month_len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
      default:                   month_len = 5'd31;
    endcase
  endfunction

  function automatic logic [15:0] cal_get(input cal_t c, input logic [2:0] idx);
    case (idx)
      3'd0:    cal_get = {10'd0, c.sec};
      3'd1:    cal_get = {10'd0, c.minute};
      3'd2:    cal_get = {11'd0, c.hour};
      3'd3:    cal_get = {11'd0, c.mday};
      3'd4:    cal_get = {13'd0, c.wday};
      3'd5:    cal_get = {12'd0, c.month};
      default: cal_get = {9'd0, c.year};
    endcase
  endfunction

  function automatic cal_t cal_set(input cal_t c, input logic [2:0] idx, input logic [15:0] v);
    cal_t r;
    r = c;
    case (idx)
      3'd0:    r.sec    = v[5:0];
      3'd1:    r.minute = v[5:0];
      3'd2:    r.hour   = v[4:0];
      3'd3:    r.mday   = v[4:0];
      3'd4:    r.wday   = v[2:0];
      3'd5:    r.month  = v[3:0];
      default: r.year   = v[6:0];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tk_regfile.sv
module tk_regfile
  import tk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  cal_t              live_i,
  input  logic              busy_i,
  output cal_t              shadow_o,
  output logic              trig_o,
  output logic [15:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] TRIG_ADDR  = ADDR_W'(8'h3C);
  localparam int                FIELD_BASE = 8'h0A;
  localparam int                BUSY_BIT   = 6;

  logic [NUM_FIELDS-1:0] fld_hit;
  logic [2:0]            fld_idx;
  cal_t                  sh_q;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
    assign fld_hit[g] = (addr_i == ADDR_W'(FIELD_BASE + 2 * g));
  end

  always_comb begin
    fld_idx = 3'd0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (fld_hit[i]) fld_idx = 3'(i);
  end

  assign trig_o = req_i && we_i && (addr_i == TRIG_ADDR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         sh_q <= CAL_RESET;
    else if (req_i && we_i && |fld_hit) sh_q <= cal_set(sh_q, fld_idx, wdata_i);
  end

  assign shadow_o = sh_q;

  always_comb begin
    rdata_o = 16'd0;
    if (|fld_hit)                 rdata_o = cal_get(live_i, fld_idx);
    else if (addr_i == STAT_ADDR) rdata_o[BUSY_BIT] = busy_i;
  end
endmodule

// File: rtl/tk_commit.sv
module tk_commit #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(BUSY_CYCLES);
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
  import tk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic commit_i,
  input  cal_t load_i,
  output cal_t live_o
);
  cal_t       cal_q, nxt;
  logic [4:0] mlen;

  assign mlen = month_len(cal_q.month, cal_q.year);

  always_comb begin
    nxt = cal_q;
    if (cal_q.sec >= 6'd59) begin
      nxt.sec = 6'd0;
      if (cal_q.minute >= 6'd59) begin
        nxt.minute = 6'd0;
        if (cal_q.hour >= 5'd23) begin
          nxt.hour = 5'd0;
          nxt.wday = (cal_q.wday >= 3'd6) ? 3'd0 : cal_q.wday + 3'd1;
          if (cal_q.mday >= mlen) begin
            nxt.mday = 5'd1;
            if (cal_q.month >= 4'd12) begin
              nxt.month = 4'd1;
              nxt.year  = cal_q.year + 7'd1;
            end else begin
              nxt.month = cal_q.month + 4'd1;
            end
          end else begin
            nxt.mday = cal_q.mday + 5'd1;
          end
        end else begin
          nxt.hour = cal_q.hour + 5'd1;
        end
      end else begin
        nxt.minute = cal_q.minute + 6'd1;
      end
    end else begin
      nxt.sec = cal_q.sec + 6'd1;
    end
  end

  // load has priority; a coincident tick is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cal_q <= CAL_RESET;
    else if (commit_i) cal_q <= load_i;
    else if (tick_i)   cal_q <= nxt;
  end

  assign live_o = cal_q;
endmodule

// File: rtl/calendar_timekeeper.sv
module calendar_timekeeper
  import tk_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o
);
  cal_t live_cal, shadow_cal;
  logic trig, busy, commit;

  tk_regfile #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .live_i(live_cal), .busy_i(busy), .shadow_o(shadow_cal),
    .trig_o(trig), .rdata_o
  );

  tk_commit #(.BUSY_CYCLES(BUSY_CYCLES)) i_commit (
    .clk_i, .rst_ni, .trig_i(trig), .busy_o(busy), .commit_o(commit)
  );

  tk_calendar i_cal (
    .clk_i, .rst_ni, .tick_i, .commit_i(commit),
    .load_i(shadow_cal), .live_o(live_cal)
  );
endmodule

// File: rtl/tk_checker.sv
module tk_checker
  import tk_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic busy,
  input logic commit,
  input cal_t live,
  input cal_t shadow
);
  AST_COMMIT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> busy);                                                     // R3
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !busy);                                                    // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !commit) |=> busy);                                          // R3
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (live == $past(shadow)));                                  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && !tick_i) |=> $stable(live));                              // R10
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !commit && live.sec < 6'd59) |=> (live.sec == $past(live.sec) + 6'd1)); // R6
  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !commit && live.sec == 6'd59 && live.minute == 6'd59 && live.hour == 5'd23 &&
     live.mday == 5'd31 && live.month == 4'd12 && live.year == 7'd127)
    |=> (live.year == 7'd0 && live.month == 4'd1 && live.mday == 5'd1)); // R8
endmodule

bind calendar_timekeeper tk_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .busy(busy),
  .commit(commit), .live(live_cal), .shadow(shadow_cal)
);

// File: tb/test_calendar_timekeeper.sv
module test_calendar_timekeeper;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 4;
  localparam int TRIG = 'h3C;
  localparam int FB   = 'h0A;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  int m_live[7], m_sh[7], m_cnt;
  bit m_busy;
  int widths[7] = '{6, 6, 5, 5, 3, 4, 7};

  always #(CLK_PERIOD/2) clk = ~clk;

  calendar_timekeeper #(.ADDR_W(8), .BUSY_CYCLES(BUSY)) i_calendar_timekeeper (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_advance();
    if (m_live[0] >= 59) begin
      m_live[0] = 0;
      if (m_live[1] >= 59) begin
        m_live[1] = 0;
        if (m_live[2] >= 23) begin
          m_live[2] = 0;
          m_live[4] = (m_live[4] >= 6) ? 0 : m_live[4] + 1;
          if (m_live[3] >= mlen(m_live[5], m_live[6])) begin
            m_live[3] = 1;
            if (m_live[5] >= 12) begin m_live[5] = 1; m_live[6] = (m_live[6] + 1) % 128; end
            else m_live[5]++;
          end else m_live[3]++;
        end else m_live[2]++;
      end else m_live[1]++;
    end else m_live[0]++;
  endtask

  task automatic m_update(bit rq, bit w, int ad, int wd, bit tk);
    bit was_busy = m_busy;
    bit cm = m_busy && m_cnt == 1;
    if (cm) for (int i = 0; i < 7; i++) m_live[i] = m_sh[i];
    else if (tk) m_advance();
    if (m_busy) begin
      if (m_cnt == 1) m_busy = 0; else m_cnt--;
    end
    if (rq && w) begin
      if (ad == TRIG && wd[0] && !was_busy) begin m_busy = 1; m_cnt = BUSY; end
      for (int i = 0; i < 7; i++)
        if (ad == FB + 2 * i) m_sh[i] = wd & ((1 << widths[i]) - 1);
    end
  endtask

  function automatic int exp_read(int ad);
    if (ad == 0) return m_busy ? 'h40 : 0;
    for (int i = 0; i < 7; i++) if (ad == FB + 2 * i) return m_live[i];
    return 0;
  endfunction

  task automatic step(bit rq, bit w, int ad, int wd, bit tk);
    @(negedge clk);
    req = rq; we = w; addr = 8'(ad); wdata = 16'(wd); tick = tk;
    @(posedge clk);
    m_update(rq, w, ad, wd, tk);
  endtask

  task automatic rd_chk(int ad, int exp, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = 8'(ad); wdata = 0; tick = 0;
    #1;
    tests++;
    if (rdata !== 16'(exp)) begin
      fails++;
      $display("FAIL %s addr=%02h actual=%0d expected=%0d", tag, ad, rdata, exp);
    end
    @(posedge clk);
    m_update(1, 0, ad, 0, 0);
  endtask

  task automatic load_time(int v[7]);
    for (int i = 0; i < 7; i++) step(1, 1, FB + 2 * i, v[i], 0);
    step(1, 1, TRIG, 1, 0);
    for (int i = 0; i < BUSY; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic chk_all(string tag);
    for (int i = 0; i < 7; i++) rd_chk(FB + 2 * i, m_live[i], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_live = '{0, 0, 0, 1, 0, 1, 0};
    m_sh = m_live; m_busy = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state, R2 map
    rd_chk('h0A, 0, "R1 sec");  rd_chk('h10, 1, "R1 mday");
    rd_chk('h14, 1, "R1 month"); rd_chk('h16, 0, "R1 year");
    rd_chk('h00, 0, "R1 status"); rd_chk('h3C, 0, "R2 trig reads 0");
    rd_chk('h02, 0, "R2 unmapped");

    // R4 staged write invisible
    step(1, 1, 'h0A, 30, 0);
    rd_chk('h0A, 0, "R4 staged not live");
    // R3 busy window and load
    step(1, 1, TRIG, 1, 0);
    for (int i = 0; i < BUSY; i++) rd_chk('h00, 'h40, "R3 busy high");
    rd_chk('h00, 0, "R3 busy cleared");
    rd_chk('h0A, 30, "R3 loaded");
    // R3 trigger while busy ignored
    step(1, 1, TRIG, 1, 0);
    step(1, 1, 'h0A, 40, 0);
    step(1, 1, TRIG, 1, 0);
    for (int i = 0; i < BUSY - 2; i++) step(0, 0, 0, 0, 0);
    rd_chk('h0A, 40, "R3 single load");
    rd_chk('h00, 0, "R3 retrigger ignored");

    // R9 tick on copy edge dropped
    step(1, 1, 'h0A, 10, 0);
    step(1, 1, TRIG, 1, 0);
    for (int i = 0; i < BUSY - 1; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    rd_chk('h0A, 10, "R9 tick dropped");
    step(0, 0, 0, 0, 1);
    rd_chk('h0A, 11, "R9 next tick counts");
    // R10 idle hold
    repeat (5) step(0, 0, 0, 0, 0);
    rd_chk('h0A, 11, "R10 hold");

    // R5 field width
    step(1, 1, 'h0A, 'hFFFF, 0); step(1, 1, 'h12, 'hFFFF, 0);
    step(1, 1, TRIG, 1, 0); repeat (BUSY) step(0, 0, 0, 0, 0);
    rd_chk('h0A, 63, "R5 sec mask"); rd_chk('h12, 7, "R5 wday mask");

    // R6 R7 leap February (year 0)
    load_time('{59, 59, 23, 28, 6, 2, 0});
    step(0, 0, 0, 0, 1);
    rd_chk('h10, 29, "R7 leap feb 29"); rd_chk('h12, 0, "R6 wday wrap");
    rd_chk('h0E, 0, "R6 hour wrap"); rd_chk('h0C, 0, "R6 minute wrap");
    // R7 common February
    load_time('{59, 59, 23, 28, 2, 2, 1});
    step(0, 0, 0, 0, 1);
    rd_chk('h10, 1, "R7 feb 28 end"); rd_chk('h14, 3, "R7 month step");
    // R7 thirty-day month
    load_time('{59, 59, 23, 30, 2, 4, 5});
    step(0, 0, 0, 0, 1);
    rd_chk('h10, 1, "R7 april end"); rd_chk('h14, 5, "R7 may");
    // R8 year wrap
    load_time('{59, 59, 23, 31, 3, 12, 127});
    step(0, 0, 0, 0, 1);
    rd_chk('h16, 0, "R8 year wrap"); rd_chk('h14, 1, "R8 month wrap");
    rd_chk('h10, 1, "R8 mday wrap");

    // random mix
    load_time('{50, 59, 23, 27, 5, 2, 3});
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(99));
      if (r < 55) step(0, 0, 0, 0, 1);
      else if (r < 70) begin
        int f = int'($urandom_range(6));
        int v = int'($urandom_range((1 << widths[f]) - 1));
        step(1, 1, FB + 2 * f, v, $urandom_range(1));
      end else if (r < 76) step(1, 1, TRIG, 1, $urandom_range(1));
      else begin
        int a = ($urandom_range(9) == 0) ? 0 : FB + 2 * int'($urandom_range(6));
        rd_chk(a, exp_read(a), "R6 R7 R9 random");
      end
    end
    chk_all("R8 final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule